// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Bank

This block holds sixteen general-purpose pins behind a 32-bit memory-mapped register bus. For each pin, software selects whether it is driven or sampled, sets the level it drives, and reads back the level that is present on the pad. Pad levels are sampled through a two-stage synchronizer and compared with the value from the previous cycle. Rising edges, falling edges or both can be turned into interrupt events. Events collect in a sticky status register. Software clears that register by writing ones to it.

The block drives one combined interrupt line, which is the OR of every pending status bit whose interrupt enable is set. It also drives one wake-up request, which pulses for a freshly detected edge on any pin whose wake enable is set. The edge mode is a two-bit code per pin. The codes for pins 0..7 sit in one control word and those for pins 8..15 in a second word. The data-out, interrupt-enable and wake-enable registers each have a write-one-to-set and a write-one-to-clear address, so software can change a single bit without reading the register first.

Bus reads are combinational from the current register state. Writes take effect at the clock edge where `bus_wr_en` is high.

Top module: `gpio_bank_top`

## Requirements
- R1: After reset, the direction register (offset 0x34) reads 0x0000FFFF and `pad_oe` is all zeros. Every other register, including offsets 0x10, 0x18, 0x1C, 0x28, 0x30, 0x38 and 0x3C, reads zero. `bank_irq` and `wake_req` are low.
- R2: A direction bit of 1 makes its pin an input, so the matching `pad_oe` bit is 0. A direction bit of 0 makes the pin an output, so the `pad_oe` bit is 1. `pad_out` always equals the data-out register. Write bits above bit 15 are ignored.
- R3: Writing 0x30 loads the data-out register. Writing 0xF0 sets each bit written as 1, and writing 0xB0 clears each bit written as 1. Bits written as 0 keep their value, and the alias offsets read as zero.
- R4: The interrupt-enable register is loaded at 0x1C, set by ones at 0xDC and cleared by ones at 0x9C. The wake-enable register is loaded at 0x28, set by ones at 0xE8 and cleared by ones at 0xA8. In both cases, bits written as 0 are unchanged.
- R5: Offset 0x2C returns the pad inputs after a two-flop synchronizer. A pad change applied before clock edge k is visible from edge k+1 on.
- R6: Pin p takes its edge code from offset 0x38 if p < 8, or from 0x3C if p >= 8, at bits [2*(p mod 8)+1 : 2*(p mod 8)]. The codes are: 00 means no detection, 01 means rising edge, 10 means falling edge and 11 means both edges.
- R7: The status register at 0x18 sets a pin's bit on every detected edge, whether or not that pin's interrupt is enabled. A bit stays set until a 1 is written to it at 0x18. Writing 0xFFFF clears every pending bit.
- R8: If a detected edge and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R9: `bank_irq` is high exactly when at least one status bit and its interrupt-enable bit are both set.
- R10: If a pin's pad changes before edge k and the change is a detected edge for that pin, `wake_req` is high between edge k+1 and edge k+2 provided the pin's wake-enable bit is set. It is high in no other cycle.
- R11: Offset 0x00 returns the major version in bits 7:4 and the minor version in bits 3:0. Offset 0x14 and unmapped offsets read zero. Writes to read-only offsets change nothing. Offset 0x10 holds an 8-bit value that can be read and written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Levels to drive on the pads |
| pad_oe | output | 16 | Per-pin output enable, 1 = drive |
| bank_irq | output | 1 | Combined interrupt request of the bank |
| wake_req | output | 1 | Wake-up request for newly detected edges |

## Verification
The assertions assume that `bus_wr_en`, `bus_addr` and `bus_wdata` are stable around each rising clock edge and carry one access per cycle. They treat `pad_in` as asynchronous and observe it only after the synchronizer. The stimulus changes all bus inputs and pad inputs only on falling clock edges, so each write lands on exactly one rising edge. It holds the pads low through reset, so no edge is seen while the block starts up. A timed scenario applies a status clear in the exact cycle in which an edge on the same pin is detected.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

    localparam int unsigned BUS_DW = 32;
    localparam int unsigned BUS_AW = 8;

    // Register byte offsets; software depends on these values.
    typedef enum logic [BUS_AW-1:0] {
        OFS_VERSION  = 8'h00,
        OFS_SCRATCH  = 8'h10,
        OFS_HEALTH   = 8'h14,
        OFS_PENDING  = 8'h18,
        OFS_IRQ_EN   = 8'h1C,
        OFS_WAKE_EN  = 8'h28,
        OFS_PAD_LVL  = 8'h2C,
        OFS_DRIVE    = 8'h30,
        OFS_IS_INPUT = 8'h34,
        OFS_MODE_LO  = 8'h38,
        OFS_MODE_HI  = 8'h3C,
        OFS_IRQ_OFF  = 8'h9C,
        OFS_WAKE_OFF = 8'hA8,
        OFS_DRV_OFF  = 8'hB0,
        OFS_IRQ_ON   = 8'hDC,
        OFS_WAKE_ON  = 8'hE8,
        OFS_DRV_ON   = 8'hF0
    } reg_ofs_e;

    // Per-pin edge code
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    // Update kind for a register with set/clear aliases
    typedef enum logic [1:0] {
        UPD_KEEP,
        UPD_LOAD,
        UPD_SET,
        UPD_CLR
    } upd_op_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    function automatic logic [BUS_DW-1:0] apply_upd(
        input upd_op_e           op,
        input logic [BUS_DW-1:0] cur,
        input logic [BUS_DW-1:0] wd
    );
        logic [BUS_DW-1:0] nxt;
        case (op)
            UPD_LOAD: nxt = wd;
            UPD_SET:  nxt = cur | wd;
            UPD_CLR:  nxt = cur & ~wd;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic edge_hit(input edge_mode_e mode, input edge_pair_t seen);
        logic hit;
        case (mode)
            EDGE_RISE: hit = seen.rise;
            EDGE_FALL: hit = seen.fall;
            EDGE_ANY:  hit = seen.rise | seen.fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_bank_edge.sv
`timescale 1ns/1ps
module gpio_bank_edge
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPIN        = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPIN-1:0]   pad_in,
    input  logic [2*NPIN-1:0] mode_q,
    output logic [NPIN-1:0]   din_sync,
    output logic [NPIN-1:0]   evt
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [SYNC_STAGES-1:0] chain_q;
        logic                   prev_q;
        edge_pair_t             seen;
        edge_mode_e             mode;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[SYNC_STAGES-2:0], pad_in[p]};
                prev_q  <= chain_q[LAST];
            end
        end

        always_comb begin
            seen.rise = chain_q[LAST] & ~prev_q;
            seen.fall = ~chain_q[LAST] & prev_q;
            mode      = edge_mode_e'(mode_q[2*p +: 2]);
        end

        assign din_sync[p] = chain_q[LAST];
        assign evt[p]      = edge_hit(mode, seen);
    end

endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPIN    = 16,
    parameter int unsigned CFG_W   = 8,
    parameter int unsigned REV_MAJ = 1,
    parameter int unsigned REV_MIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    output logic [BUS_DW-1:0] rdata,
    input  logic [NPIN-1:0]   evt,
    input  logic [NPIN-1:0]   din_sync,
    output logic [NPIN-1:0]   dir_q,
    output logic [NPIN-1:0]   dout_q,
    output logic [NPIN-1:0]   ien_q,
    output logic [NPIN-1:0]   wen_q,
    output logic [NPIN-1:0]   pend_q,
    output logic [2*NPIN-1:0] mode_q
);

    localparam int unsigned MW       = 2 * NPIN;
    localparam int unsigned HALF     = BUS_DW / 2;
    localparam int unsigned PINS_LO  = HALF / 2;

    reg_ofs_e          ofs;
    upd_op_e           dout_op, ien_op, wen_op;
    logic              dir_ld, cfg_ld, mlo_ld, mhi_ld;
    logic [NPIN-1:0]   clr_mask;
    logic [NPIN-1:0]   dout_d, ien_d, wen_d, pend_d;
    logic [BUS_DW-1:0] mode_ext, mode_new;
    logic [CFG_W-1:0]  cfg_q;
    logic              unused_hi_bits;

    assign ofs            = reg_ofs_e'(addr);
    assign unused_hi_bits = ^wdata[BUS_DW-1:NPIN];

    // Write decode
    always_comb begin
        dout_op  = UPD_KEEP;
        ien_op   = UPD_KEEP;
        wen_op   = UPD_KEEP;
        dir_ld   = 1'b0;
        cfg_ld   = 1'b0;
        mlo_ld   = 1'b0;
        mhi_ld   = 1'b0;
        clr_mask = '0;
        if (wr_en) begin
            case (ofs)
                OFS_DRIVE:    dout_op  = UPD_LOAD;
                OFS_DRV_ON:   dout_op  = UPD_SET;
                OFS_DRV_OFF:  dout_op  = UPD_CLR;
                OFS_IRQ_EN:   ien_op   = UPD_LOAD;
                OFS_IRQ_ON:   ien_op   = UPD_SET;
                OFS_IRQ_OFF:  ien_op   = UPD_CLR;
                OFS_WAKE_EN:  wen_op   = UPD_LOAD;
                OFS_WAKE_ON:  wen_op   = UPD_SET;
                OFS_WAKE_OFF: wen_op   = UPD_CLR;
                OFS_IS_INPUT: dir_ld   = 1'b1;
                OFS_SCRATCH:  cfg_ld   = 1'b1;
                OFS_MODE_LO:  mlo_ld   = 1'b1;
                OFS_MODE_HI:  mhi_ld   = 1'b1;
                OFS_PENDING:  clr_mask = wdata[NPIN-1:0];
                default:      ;
            endcase
        end
    end

    // Next-state values
    always_comb begin
        dout_d = NPIN'(apply_upd(dout_op, BUS_DW'(dout_q), wdata));
        ien_d  = NPIN'(apply_upd(ien_op,  BUS_DW'(ien_q),  wdata));
        wen_d  = NPIN'(apply_upd(wen_op,  BUS_DW'(wen_q),  wdata));
        // A detected edge outranks a same-cycle clear
        pend_d = (pend_q & ~clr_mask) | evt;

        mode_ext         = '0;
        mode_ext[MW-1:0] = mode_q;
        mode_new         = mode_ext;
        if (mlo_ld) mode_new[HALF-1:0]      = wdata[HALF-1:0];
        if (mhi_ld) mode_new[BUS_DW-1:HALF] = wdata[HALF-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            dout_q <= '0;
            ien_q  <= '0;
            wen_q  <= '0;
            pend_q <= '0;
            mode_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (dir_ld) dir_q <= wdata[NPIN-1:0];
            if (cfg_ld) cfg_q <= wdata[CFG_W-1:0];
            dout_q <= dout_d;
            ien_q  <= ien_d;
            wen_q  <= wen_d;
            pend_q <= pend_d;
            mode_q <= mode_new[MW-1:0];
        end
    end

    // Read mux
    always_comb begin
        case (ofs)
            OFS_VERSION:  rdata = BUS_DW'({4'(REV_MAJ), 4'(REV_MIN)});
            OFS_SCRATCH:  rdata = BUS_DW'(cfg_q);
            OFS_PENDING:  rdata = BUS_DW'(pend_q);
            OFS_IRQ_EN:   rdata = BUS_DW'(ien_q);
            OFS_WAKE_EN:  rdata = BUS_DW'(wen_q);
            OFS_PAD_LVL:  rdata = BUS_DW'(din_sync);
            OFS_DRIVE:    rdata = BUS_DW'(dout_q);
            OFS_IS_INPUT: rdata = BUS_DW'(dir_q);
            OFS_MODE_LO:  rdata = BUS_DW'(mode_ext[HALF-1:0]);
            OFS_MODE_HI:  rdata = BUS_DW'(mode_ext[BUS_DW-1:HALF]);
            default:      rdata = '0;
        endcase
    end

    if (NPIN > 2 * PINS_LO) begin : g_bad_npin
        initial $error("gpio_bank_regs: NPIN exceeds two mode words");
    end

endmodule

// File: rtl/gpio_bank_irq.sv
`timescale 1ns/1ps
module gpio_bank_irq #(
    parameter int unsigned NPIN = 16
) (
    input  logic [NPIN-1:0] pend_q,
    input  logic [NPIN-1:0] ien_q,
    input  logic [NPIN-1:0] evt,
    input  logic [NPIN-1:0] wen_q,
    output logic            bank_irq,
    output logic            wake_req
);

    assign bank_irq = |(pend_q & ien_q);
    assign wake_req = |(evt & wen_q);

endmodule

// File: rtl/gpio_bank_top.sv
`timescale 1ns/1ps
module gpio_bank_top
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPIN        = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CFG_W       = 8,
    parameter int unsigned REV_MAJ     = 1,
    parameter int unsigned REV_MIN     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              bank_irq,
    output logic              wake_req
);

    localparam int unsigned MW = 2 * NPIN;

    logic [NPIN-1:0] din_sync, evt;
    logic [NPIN-1:0] dir_q, dout_q, ien_q, wen_q, pend_q;
    logic [MW-1:0]   mode_q;

    gpio_bank_edge #(
        .NPIN        (NPIN),
        .SYNC_STAGES (SYNC_STAGES)
    ) edge_i (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .mode_q   (mode_q),
        .din_sync (din_sync),
        .evt      (evt)
    );

    gpio_bank_regs #(
        .NPIN    (NPIN),
        .CFG_W   (CFG_W),
        .REV_MAJ (REV_MAJ),
        .REV_MIN (REV_MIN)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .evt      (evt),
        .din_sync (din_sync),
        .dir_q    (dir_q),
        .dout_q   (dout_q),
        .ien_q    (ien_q),
        .wen_q    (wen_q),
        .pend_q   (pend_q),
        .mode_q   (mode_q)
    );

    gpio_bank_irq #(
        .NPIN (NPIN)
    ) irq_i (
        .pend_q   (pend_q),
        .ien_q    (ien_q),
        .evt      (evt),
        .wen_q    (wen_q),
        .bank_irq (bank_irq),
        .wake_req (wake_req)
    );

    assign pad_out = dout_q;
    assign pad_oe  = ~dir_q;

endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPIN = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_en,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe,
    input logic              bank_irq,
    input logic              wake_req,
    input logic [NPIN-1:0]   pend_q,
    input logic [NPIN-1:0]   ien_q,
    input logic [NPIN-1:0]   wen_q,
    input logic [NPIN-1:0]   evt
);

    logic unused_hi_bits;
    assign unused_hi_bits = ^bus_wdata[BUS_DW-1:NPIN];

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0) && !bank_irq && !wake_req);

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == OFS_IS_INPUT) |=> pad_oe == ~$past(bus_wdata[NPIN-1:0]));

    // R3
    drive_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == OFS_DRV_ON) |=>
        ((pad_out & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])) &&
        ((pad_out & ~$past(bus_wdata[NPIN-1:0])) == ($past(pad_out) & ~$past(bus_wdata[NPIN-1:0]))));

    // R3
    drive_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == OFS_DRV_OFF) |=>
        ((pad_out & $past(bus_wdata[NPIN-1:0])) == '0) &&
        ((pad_out & ~$past(bus_wdata[NPIN-1:0])) == ($past(pad_out) & ~$past(bus_wdata[NPIN-1:0]))));

    // R4
    irq_on_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == OFS_IRQ_ON) |=>
        (ien_q == ($past(ien_q) | $past(bus_wdata[NPIN-1:0]))));

    // R7
    pending_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr_en && bus_addr == OFS_PENDING) |=> (pend_q & $past(pend_q)) == $past(pend_q));

    // R7
    event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> (pend_q & $past(evt)) == $past(evt));

    // R8
    clear_loses_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == OFS_PENDING && ((evt & bus_wdata[NPIN-1:0]) != '0)) |=>
        (pend_q & $past(evt & bus_wdata[NPIN-1:0])) == $past(evt & bus_wdata[NPIN-1:0]));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ien_q) == '0) |-> !bank_irq);

    // R10
    wake_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> ((evt & wen_q) != '0));

endmodule

bind gpio_bank_top gpio_bank_chk #(.NPIN(NPIN)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .bank_irq  (bank_irq),
    .wake_req  (wake_req),
    .pend_q    (pend_q),
    .ien_q     (ien_q),
    .wen_q     (wen_q),
    .evt       (evt)
);

// File: tb/gpio_bank_top_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr_en;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic        bank_irq;
    logic        wake_req;

    always #2 clk = ~clk;

    gpio_bank_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .bank_irq  (bank_irq),
        .wake_req  (wake_req)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Behavioural reference state
    logic [15:0] m_s1, m_s2, m_prev;
    logic [15:0] m_dir, m_dout, m_ien, m_wen, m_pend, m_lo, m_hi;
    logic [7:0]  m_cfg;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] m_evt();
        logic [15:0] e = '0;
        for (int p = 0; p < 16; p++) begin
            int  code;
            bit  up, dn;
            code = (p < 8) ? int'((m_lo >> (2 * p)) & 16'h3)
                           : int'((m_hi >> (2 * (p - 8))) & 16'h3);
            up = m_s2[p] && !m_prev[p];
            dn = !m_s2[p] && m_prev[p];
            e[p] = (code == 1 && up) || (code == 2 && dn) || (code == 3 && (up || dn));
        end
        return e;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00:   return 32'h13;
            8'h10:   return {24'h0, m_cfg};
            8'h18:   return {16'h0, m_pend};
            8'h1C:   return {16'h0, m_ien};
            8'h28:   return {16'h0, m_wen};
            8'h2C:   return {16'h0, m_s2};
            8'h30:   return {16'h0, m_dout};
            8'h34:   return {16'h0, m_dir};
            8'h38:   return {16'h0, m_lo};
            8'h3C:   return {16'h0, m_hi};
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_step();
        logic [15:0] ev, clr, wd;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0;
            m_dir = 16'hFFFF; m_dout = '0; m_ien = '0; m_wen = '0;
            m_pend = '0; m_lo = '0; m_hi = '0; m_cfg = '0;
        end else begin
            ev  = m_evt();
            wd  = bus_wdata[15:0];
            clr = '0;
            if (bus_wr_en) begin
                case (bus_addr)
                    8'h10: m_cfg  = bus_wdata[7:0];
                    8'h18: clr    = wd;
                    8'h1C: m_ien  = wd;
                    8'hDC: m_ien  = m_ien | wd;
                    8'h9C: m_ien  = m_ien & ~wd;
                    8'h28: m_wen  = wd;
                    8'hE8: m_wen  = m_wen | wd;
                    8'hA8: m_wen  = m_wen & ~wd;
                    8'h30: m_dout = wd;
                    8'hF0: m_dout = m_dout | wd;
                    8'hB0: m_dout = m_dout & ~wd;
                    8'h34: m_dir  = wd;
                    8'h38: m_lo   = wd;
                    8'h3C: m_hi   = wd;
                    default: ;
                endcase
            end
            m_pend = (m_pend & ~clr) | ev;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad_in;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        m_step();
        @(negedge clk);
        check("R2", {16'h0, pad_oe}, {16'h0, ~m_dir});
        check("R3", {16'h0, pad_out}, {16'h0, m_dout});
        check("R9", {31'h0, bank_irq}, {31'h0, |(m_pend & m_ien)});
        check("R10", {31'h0, wake_req}, {31'h0, |(m_evt() & m_wen)});
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        tick();
        bus_wr_en = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, m_read(a));
        tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog
    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=complete");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] offs [14];
        offs = '{8'h10, 8'h18, 8'h1C, 8'h28, 8'h30, 8'h34, 8'h38,
                 8'h3C, 8'h9C, 8'hA8, 8'hB0, 8'hDC, 8'hE8, 8'hF0};
        rst = 1'b1; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        check("R1", {31'h0, bank_irq}, 32'h0);
        check("R1", {16'h0, pad_oe}, 32'h0);
        rd_chk("R1", 8'h34);
        rd_chk("R1", 8'h30);
        rd_chk("R1", 8'h18);
        rd_chk("R1", 8'h1C);
        rd_chk("R1", 8'h28);
        rd_chk("R1", 8'h38);
        rd_chk("R1", 8'h3C);
        rd_chk("R1", 8'h10);

        // R11 identification and read-only offsets
        rd_chk("R11", 8'h00);
        check("R11", bus_rdata, 32'h13);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R11", 8'h00);
        rd_chk("R11", 8'h14);
        rd_chk("R11", 8'h44);
        wr(8'h10, 32'h0000_01A5);
        rd_chk("R11", 8'h10);

        // R2 direction
        wr(8'h34, 32'hFFFF_00F0);
        check("R2", {16'h0, pad_oe}, 32'h0000_FF0F);
        rd_chk("R2", 8'h34);

        // R3 data out with aliases
        wr(8'h30, 32'h0);
        wr(8'hF0, 32'h0005);
        rd_chk("R3", 8'h30);
        wr(8'hF0, 32'h0100);
        wr(8'hB0, 32'h0004);
        check("R3", {16'h0, pad_out}, 32'h0101);
        rd_chk("R3", 8'h30);
        rd_chk("R3", 8'hF0);

        // R4 enable aliases
        wr(8'h1C, 32'h00FF);
        wr(8'h9C, 32'h000F);
        wr(8'hDC, 32'h0100);
        rd_chk("R4", 8'h1C);
        wr(8'h28, 32'h0003);
        wr(8'hE8, 32'h8000);
        wr(8'hA8, 32'h0002);
        rd_chk("R4", 8'h28);
        check("R4", bus_rdata, 32'h8001);
        wr(8'h1C, 32'h0);

        // R5 synchronizer latency
        pad_in = 16'h1234;
        tick();
        rd_chk("R5", 8'h2C);
        rd_chk("R5", 8'h2C);
        pad_in = 16'h0000;
        repeat (3) tick();

        // R6 edge field map: pin0 rise, pin1 fall, pin2 both, pin8 both, pin15 rise
        wr(8'h38, 32'h0000_0039);
        wr(8'h3C, 32'h0000_4003);
        rd_chk("R6", 8'h38);
        repeat (2) tick();
        wr(8'h18, 32'hFFFF);
        pad_in = 16'h800F;
        repeat (3) tick();
        rd_chk("R6", 8'h18);
        check("R6", bus_rdata, 32'h8005);
        pad_in = 16'h0100;
        repeat (3) tick();
        rd_chk("R6", 8'h18);

        // R7 sticky status, set while disabled, write-one-to-clear
        rd_chk("R7", 8'h18);
        wr(8'h18, 32'h0004);
        rd_chk("R7", 8'h18);
        wr(8'h18, 32'hFFFF);
        rd_chk("R7", 8'h18);
        check("R7", bus_rdata, 32'h0);

        // R9 combined interrupt
        wr(8'h1C, 32'h0001);
        pad_in = 16'h0101;
        repeat (3) tick();
        check("R9", {31'h0, bank_irq}, 32'h1);
        wr(8'h18, 32'h0001);
        check("R9", {31'h0, bank_irq}, 32'h0);

        // R8 clear and edge in the same cycle; R10 wake pulse
        pad_in = 16'h0100;
        repeat (3) tick();
        wr(8'h18, 32'hFFFF);
        pad_in = 16'h0101;
        tick();
        tick();
        check("R10", {31'h0, wake_req}, 32'h1);
        wr(8'h18, 32'hFFFF);
        check("R10", {31'h0, wake_req}, 32'h0);
        rd_chk("R8", 8'h18);
        check("R8", bus_rdata, 32'h0001);

        // Mixed traffic against the reference
        for (int i = 0; i < 600; i++) begin
            pad_in = 16'($urandom);
            if (($urandom % 3) == 0) begin
                wr(offs[$urandom % 14], $urandom);
            end else begin
                rd_chk("R7", offs[$urandom % 14]);
            end
        end
        rd_chk("R6", 8'h18);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule